// File: doc/BRIEF.md
# Matmul Output-Tile Walk Sequencer

This block drives the loop structure of a tiled matrix multiply on a single compute core. A job is described by the core's share of the problem (rows of the result, columns of the result, and the reduction depth) and by the basic block size along each of those three axes. When the job starts, the block walks every block-sized tile of the result matrix. For each result tile it walks every slice of the reduction axis. Each step is one command. A command carries the row offset, the column offset and the reduction offset, the valid extent along each axis, and two flags that mark the first and the last reduction slice of the tile.

A runtime order input picks which result axis moves fastest. With order 0 the row index moves fastest. With order 1 the column index moves fastest. The reduction loop is always innermost. The tile counts use ceiling division, so the last tile along an axis may be smaller than the base size, and its true extent appears on the length outputs. Commands leave through a valid/ready handshake. A one-cycle done pulse closes the job. Moving data and doing arithmetic are left to the consumers of the commands.

Top module: `mm_tile_walker`

## Requirements
- R1: A start pulse while the block is idle captures all six size inputs and the order input, and `cmd_valid` is high from the next cycle. A start pulse, or any change to the size or order inputs, while a job is running or finishing has no effect on the command stream.
- R2: For every result tile, the reduction offsets run 0, baseK, 2·baseK, … through all ceil(coreK/baseK) slices. `cmd_k_first` is high only on the slice at offset 0, and `cmd_k_last` is high only on the final slice.
- R3: With order 0, the row tile index advances after each finished tile. When it wraps to 0, the column tile index advances.
- R4: With order 1, the column tile index advances after each finished tile. When it wraps to 0, the row tile index advances.
- R5: Tile counts per axis are ceil(core/base). The length output of an axis equals base, except on the last tile, where it equals core minus that tile's offset.
- R6: The sequence advances only on a cycle with `cmd_valid` and `cmd_ready` both high. While `cmd_ready` is low, every command output holds its value.
- R7: `done` is high for exactly one cycle: the cycle after the final command is accepted. `cmd_valid` is low in that cycle.
- R8: After reset, `cmd_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (honoured only when idle) |
| order_n_first | input | 1 | 0: row index moves first, 1: column index moves first |
| core_m | input | DIM_W | Result rows handled by this core |
| core_n | input | DIM_W | Result columns handled by this core |
| core_k | input | DIM_W | Reduction depth |
| base_m | input | DIM_W | Tile height |
| base_n | input | DIM_W | Tile width |
| base_k | input | DIM_W | Reduction slice depth |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Consumer accepts command |
| cmd_m_off | output | DIM_W | Row offset of tile |
| cmd_n_off | output | DIM_W | Column offset of tile |
| cmd_k_off | output | DIM_W | Reduction offset of slice |
| cmd_m_len | output | DIM_W | Valid rows in tile |
| cmd_n_len | output | DIM_W | Valid columns in tile |
| cmd_k_len | output | DIM_W | Valid depth in slice |
| cmd_k_first | output | 1 | First reduction slice of tile |
| cmd_k_last | output | 1 | Last reduction slice of tile |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench builds the block with DIM_W set to 10. At that width a directed job with core size 1023 and base size 600 pushes the offset-plus-base sum past the 10-bit range. This checks that the end-of-axis test uses the carry bit and does not wrap. The other jobs keep dimensions small enough that both orders, partial edge tiles, single-tile jobs, random back-pressure, and a start pulse with changed sizes in the middle of a job all fit inside a short run.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mtw_state_e;

    localparam int AX_M   = 0;
    localparam int AX_N   = 1;
    localparam int AX_K   = 2;
    localparam int NUM_AX = 3;

    // Selects which output axis is stepped by a finished tile.
    function automatic int fast_axis(input logic n_first);
        return n_first ? AX_N : AX_M;
    endfunction

endpackage

// File: rtl/mtw_axis_cnt.sv
module mtw_axis_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_total,
    input  logic [W-1:0] load_base,
    input  logic         step,
    output logic [W-1:0] off,
    output logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] total_q;
    logic [W-1:0] base_q;
    logic [W-1:0] off_q;
    logic [W:0]   reach;

    // one extra bit so offset+base never wraps
    assign reach = {1'b0, off_q} + {1'b0, base_q};
    assign last  = reach >= {1'b0, total_q};
    assign len   = last ? (total_q - off_q) : base_q;
    assign off   = off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= '0;
            base_q  <= '0;
            off_q   <= '0;
        end else if (load) begin
            total_q <= load_total;
            base_q  <= load_base;
            off_q   <= '0;
        end else if (step) begin
            off_q <= last ? '0 : reach[W-1:0];
        end
    end

    // R5: a tile extent never exceeds the base size and is never empty
    p_len_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (step && base_q != '0 && total_q != '0) |-> (len != '0 && len <= base_q));

endmodule

// File: rtl/mtw_ctrl.sv
module mtw_ctrl
    import mtw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic fire,
    input  logic final_cmd,
    output logic load,
    output logic cmd_valid,
    output logic done
);
    mtw_state_e state_q;
    mtw_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (fire && final_cmd) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign load      = (state_q == ST_IDLE) && start;
    assign cmd_valid = (state_q == ST_RUN);
    assign done      = (state_q == ST_FIN);

    // R7: done is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: the final accepted command is followed by done
    p_final_done_r7: assert property (@(posedge clk) disable iff (rst)
        (fire && final_cmd) |=> (done && !cmd_valid));

    // R1: a running job keeps running whatever start does
    p_run_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !(fire && final_cmd)) |=> cmd_valid);

endmodule

// File: rtl/mm_tile_walker.sv
module mm_tile_walker
    import mtw_pkg::*;
#(
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             order_n_first,
    input  logic [DIM_W-1:0] core_m,
    input  logic [DIM_W-1:0] core_n,
    input  logic [DIM_W-1:0] core_k,
    input  logic [DIM_W-1:0] base_m,
    input  logic [DIM_W-1:0] base_n,
    input  logic [DIM_W-1:0] base_k,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [DIM_W-1:0] cmd_m_off,
    output logic [DIM_W-1:0] cmd_n_off,
    output logic [DIM_W-1:0] cmd_k_off,
    output logic [DIM_W-1:0] cmd_m_len,
    output logic [DIM_W-1:0] cmd_n_len,
    output logic [DIM_W-1:0] cmd_k_len,
    output logic             cmd_k_first,
    output logic             cmd_k_last,
    output logic             done
);
    logic             load;
    logic             fire;
    logic             final_cmd;
    logic             order_q;
    logic             valid_w;

    logic [DIM_W-1:0] ax_total [NUM_AX];
    logic [DIM_W-1:0] ax_base  [NUM_AX];
    logic [DIM_W-1:0] ax_off   [NUM_AX];
    logic [DIM_W-1:0] ax_len   [NUM_AX];
    logic             ax_last  [NUM_AX];
    logic             ax_step  [NUM_AX];

    always_comb begin
        ax_total[AX_M] = core_m;
        ax_total[AX_N] = core_n;
        ax_total[AX_K] = core_k;
        ax_base[AX_M]  = base_m;
        ax_base[AX_N]  = base_n;
        ax_base[AX_K]  = base_k;
    end

    always_ff @(posedge clk) begin
        if (rst)       order_q <= 1'b0;
        else if (load) order_q <= order_n_first;
    end

    assign fire      = valid_w && cmd_ready;
    assign final_cmd = ax_last[AX_K] && ax_last[AX_M] && ax_last[AX_N];

    // K always moves; the fast output axis moves when K wraps; the slow
    // output axis moves when both K and the fast axis wrap.
    always_comb begin
        ax_step[AX_K] = fire;
        for (int a = 0; a < NUM_AX; a++) begin
            if (a != AX_K) begin
                if (fast_axis(order_q) == a)
                    ax_step[a] = fire && ax_last[AX_K];
                else
                    ax_step[a] = fire && ax_last[AX_K] && ax_last[fast_axis(order_q)];
            end
        end
    end

    for (genvar g = 0; g < NUM_AX; g++) begin : g_axis
        mtw_axis_cnt #(.W(DIM_W)) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .load_total (ax_total[g]),
            .load_base  (ax_base[g]),
            .step       (ax_step[g]),
            .off        (ax_off[g]),
            .len        (ax_len[g]),
            .last       (ax_last[g])
        );
    end

    mtw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .fire      (fire),
        .final_cmd (final_cmd),
        .load      (load),
        .cmd_valid (valid_w),
        .done      (done)
    );

    assign cmd_valid   = valid_w;
    assign cmd_m_off   = ax_off[AX_M];
    assign cmd_n_off   = ax_off[AX_N];
    assign cmd_k_off   = ax_off[AX_K];
    assign cmd_m_len   = ax_len[AX_M];
    assign cmd_n_len   = ax_len[AX_N];
    assign cmd_k_len   = ax_len[AX_K];
    assign cmd_k_first = (ax_off[AX_K] == '0);
    assign cmd_k_last  = ax_last[AX_K];

    // R6: a stalled command holds every field
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_m_off) &&
            $stable(cmd_n_off) && $stable(cmd_k_off)));

    // R2: a finished tile is followed by a first slice
    p_new_tile_first_r2: assert property (@(posedge clk) disable iff (rst)
        (fire && cmd_k_last && !final_cmd) |=> cmd_k_first);

    // R3: with order 0 the column offset holds while rows remain
    p_row_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && !order_q && cmd_k_last && !ax_last[AX_M]) |=> $stable(cmd_n_off));

    // R4: with order 1 the row offset holds while columns remain
    p_col_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && order_q && cmd_k_last && !ax_last[AX_N]) |=> $stable(cmd_m_off));

endmodule

// File: tb/mm_tile_walker_tb_top.sv
module mm_tile_walker_tb_top;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic         order_n_first;
    logic [W-1:0] core_m, core_n, core_k, base_m, base_n, base_k;
    logic         cmd_valid, cmd_ready;
    logic [W-1:0] cmd_m_off, cmd_n_off, cmd_k_off;
    logic [W-1:0] cmd_m_len, cmd_n_len, cmd_k_len;
    logic         cmd_k_first, cmd_k_last, done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    mm_tile_walker #(.DIM_W(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .order_n_first(order_n_first),
        .core_m(core_m), .core_n(core_n), .core_k(core_k),
        .base_m(base_m), .base_n(base_n), .base_k(base_k),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_m_off(cmd_m_off), .cmd_n_off(cmd_n_off), .cmd_k_off(cmd_k_off),
        .cmd_m_len(cmd_m_len), .cmd_n_len(cmd_n_len), .cmd_k_len(cmd_k_len),
        .cmd_k_first(cmd_k_first), .cmd_k_last(cmd_k_last), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int ext(input int idx, input int base, input int total);
        int rem = total - idx * base;
        return (rem < base) ? rem : base;
    endfunction

    task automatic run_job(input int cm, input int cn, input int ck,
                           input int bm, input int bn, input int bk,
                           input bit ord, input int pct, input bit poke);
        int mi = cdiv(cm, bm);
        int ni = cdiv(cn, bn);
        int ki = cdiv(ck, bk);
        int total = mi * ni * ki;
        int em = 0, en = 0, ek = 0, cnt = 0;
        bit stalled = 0;
        string rq_o = ord ? "R4" : "R3";
        core_m = W'(cm); core_n = W'(cn); core_k = W'(ck);
        base_m = W'(bm); base_n = W'(bn); base_k = W'(bk);
        order_n_first = ord;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cmd_valid == 1'b1, "R1", "valid after start", int'(cmd_valid), 1);
        while (cnt < total) begin
            chk(cmd_valid == 1'b1, stalled ? "R6" : "R1", "valid", int'(cmd_valid), 1);
            chk(int'(cmd_m_off) == em * bm, stalled ? "R6" : rq_o, "m_off", int'(cmd_m_off), em * bm);
            chk(int'(cmd_n_off) == en * bn, stalled ? "R6" : rq_o, "n_off", int'(cmd_n_off), en * bn);
            chk(int'(cmd_k_off) == ek * bk, stalled ? "R6" : "R2", "k_off", int'(cmd_k_off), ek * bk);
            chk(int'(cmd_m_len) == ext(em, bm, cm), "R5", "m_len", int'(cmd_m_len), ext(em, bm, cm));
            chk(int'(cmd_n_len) == ext(en, bn, cn), "R5", "n_len", int'(cmd_n_len), ext(en, bn, cn));
            chk(int'(cmd_k_len) == ext(ek, bk, ck), "R5", "k_len", int'(cmd_k_len), ext(ek, bk, ck));
            chk(cmd_k_first == (ek == 0), "R2", "k_first", int'(cmd_k_first), int'(ek == 0));
            chk(cmd_k_last == (ek == ki - 1), "R2", "k_last", int'(cmd_k_last), int'(ek == ki - 1));
            if (poke && cnt == 1) begin
                // R1: start with other sizes mid-job must be ignored
                start = 1'b1;
                core_m = 10'd3; core_n = 10'd3; core_k = 10'd3;
                base_m = 10'd1; base_n = 10'd1; base_k = 10'd1;
                order_n_first = ~ord;
            end
            cmd_ready = (($urandom % 100) < pct) || (cnt == total - 1 && stalled);
            stalled = !cmd_ready;
            if (cmd_ready) begin
                cnt++;
                ek++;
                if (ek == ki) begin
                    ek = 0;
                    if (!ord) begin
                        em++;
                        if (em == mi) begin em = 0; en++; end
                    end else begin
                        en++;
                        if (en == ni) begin en = 0; em++; end
                    end
                end
            end
            @(negedge clk);
            start = 1'b0;
        end
        cmd_ready = 1'b0;
        chk(done == 1'b1, poke ? "R1" : "R7", "done after final", int'(done), 1);
        chk(cmd_valid == 1'b0, "R7", "valid in done cycle", int'(cmd_valid), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done one cycle", int'(done), 0);
        chk(cmd_valid == 1'b0, "R7", "idle after done", int'(cmd_valid), 0);
    endtask

    initial begin
        int guard = 0;
        forever begin
            @(posedge clk);
            guard++;
            if (guard > 150000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; start = 1'b0; cmd_ready = 1'b0; order_n_first = 1'b0;
        core_m = '0; core_n = '0; core_k = '0;
        base_m = '0; base_n = '0; base_k = '0;
        repeat (3) @(negedge clk);
        chk(cmd_valid == 1'b0, "R8", "valid in reset", int'(cmd_valid), 0);
        chk(done == 1'b0, "R8", "done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_valid == 1'b0, "R8", "valid after reset", int'(cmd_valid), 0);

        run_job(4, 4, 4, 2, 2, 2, 1'b0, 100, 1'b0);   // R3 even tiles
        run_job(4, 4, 4, 2, 2, 2, 1'b1, 100, 1'b0);   // R4 even tiles
        run_job(7, 5, 3, 3, 2, 2, 1'b0, 60, 1'b0);    // R5 partial edges
        run_job(7, 5, 3, 3, 2, 2, 1'b1, 60, 1'b0);
        run_job(1, 1, 1, 4, 4, 4, 1'b0, 100, 1'b0);   // single command
        run_job(1023, 1023, 10, 600, 600, 10, 1'b1, 80, 1'b0); // carry case
        run_job(6, 6, 6, 2, 3, 2, 1'b0, 50, 1'b1);    // R1 start while busy
        run_job(5, 9, 8, 5, 4, 3, 1'b1, 40, 1'b1);

        for (int j = 0; j < 10; j++) begin
            run_job(1 + int'($urandom % 24), 1 + int'($urandom % 24),
                    1 + int'($urandom % 24), 4 + int'($urandom % 9),
                    4 + int'($urandom % 9), 4 + int'($urandom % 9),
                    bit'($urandom % 2), 30 + int'($urandom % 71), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule